// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Interface

This block holds the digital side of a two-channel converter that is written over a parallel bus. Each channel owns a staging register, which a write fills, and an output register, whose 14-bit code drives the converter. A separate load strobe moves staged codes into the output registers. Because of this, one channel can be staged while the other keeps its code, and both channels can then be updated on the same clock edge. A 2-bit address picks channel A, channel B, both channels, or neither channel.

All bus pins (write strobe, load strobe, address, data) pass through synchroniser flops into the system clock domain. A registered mode state machine then decodes the synchronised strobes. It has four states: MODE_IDLE (write high, load low), MODE_CAPTURE (write low, load low), MODE_UPDATE (write high, load high) and MODE_PASS (write low, load high). The state register reloads every cycle from the synchronised strobe pair, so any state can move to any other state in one cycle. The transitions are named after the state they enter: enter-idle, enter-capture, enter-update and enter-pass.

The address is latched when the synchronised write strobe falls. Both capture and update act on the channels that the latched address selects. A power-on reset input and a clear input both load every register with a reset code. The reset code is zero or mid-scale, chosen by a select level. Both resets assert asynchronously and release on the clock.

Top module: `dual_dac_regif`

## Requirements
- R1: While `por_n` is low, all four registers hold the reset code, and both `code_a` and `code_b` show it.
- R2: The reset code is 0x0000 when `clr_mid` is 0 and 0x2000 (bit 13 set, bit 13 being the most significant) when `clr_mid` is 1. While a reset is held, the code follows `clr_mid` on each clock.
- R3: `clr_n` low forces both outputs to the reset code without waiting for a clock edge. While it is low it overrides every strobe. It also resets both staging registers, and after any reset the latched address selects both channels.
- R4: With `wstb_n` low and `load_en` low, the staging registers of the selected channels take `din`, and the outputs do not change.
- R5: Address decode: 2'b00 selects channel A, 2'b11 selects channel B, 2'b10 selects both channels, and 2'b01 selects no channel. A write with 2'b01 changes no register.
- R6: With `wstb_n` high and `load_en` high, the output register of each channel selected by the latched address copies that channel's staging register.
- R7: With `wstb_n` high and `load_en` low, no register changes. Changes on `din`, `sel_addr` or `clr_mid` outside reset have no effect.
- R8: With `wstb_n` low and `load_en` high, both the staging and the output registers of the selected channels take `din`.
- R9: When `wstb_n` and `load_en` are driven together as one low pulse, the channel selected at the falling edge shows the pulse's data once the pulse has risen.
- R10: The address is latched when the synchronised write strobe falls. Address changes while the strobe stays low are ignored, and update uses the latched value.
- R11: A change on the strobe, address or data pins shows on the outputs at the fourth rising clock edge after it, counting the first edge after the change as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| clr_n | input | 1 | Clear to reset code, active low, asynchronous assert |
| clr_mid | input | 1 | Reset code select: 0 zero, 1 mid-scale |
| wstb_n | input | 1 | Write strobe, active low |
| load_en | input | 1 | Load strobe, active high |
| sel_addr | input | 2 | Channel address (00 A, 01 none, 10 both, 11 B) |
| din | input | 14 | Data bus, bit 13 most significant |
| code_a | output | 14 | Channel A output register |
| code_b | output | 14 | Channel B output register |

## Verification
The strobe pair is driven through all four of its combinations. Staged-only writes show that capture alone leaves the outputs untouched. Update pulses show that the copy obeys the latched address and not the live one. The transparent and tied-pulse patterns tell the one-step path apart from the two-step path. Every address code, including the no-channel code, is followed by a load so that its effect is visible at the outputs. The clear is asserted mid-cycle with active strobes to show that it acts asynchronously and takes priority. A transparent write is timed edge by edge to pin down the four-edge latency.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int CH_N = 2;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_CAPTURE = 2'd1,
        MODE_UPDATE  = 2'd2,
        MODE_PASS    = 2'd3
    } mode_e;

    localparam logic [1:0] ADR_CH_A = 2'b00;
    localparam logic [1:0] ADR_NONE = 2'b01;
    localparam logic [1:0] ADR_BOTH = 2'b10;
    localparam logic [1:0] ADR_CH_B = 2'b11;

    // returns {select B, select A}
    function automatic logic [CH_N-1:0] adr_decode(input logic [1:0] adr);
        logic [CH_N-1:0] sel;
        unique case (adr)
            ADR_CH_A: sel = 2'b01;
            ADR_NONE: sel = 2'b00;
            ADR_BOTH: sel = 2'b11;
            ADR_CH_B: sel = 2'b10;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b1};
        end
    end

    assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/dacif_ctrl_fsm.sv
module dacif_ctrl_fsm
    import dacif_pkg::*;
#(
    parameter int DW = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wstb_s_n,
    input  logic            load_s,
    input  logic [1:0]      adr_s,
    input  logic [DW-1:0]   dat_s,
    output logic [CH_N-1:0] stage_we,
    output logic [CH_N-1:0] out_from_stage,
    output logic [CH_N-1:0] out_from_bus,
    output logic [DW-1:0]   dat_q
);
    mode_e           st, st_nxt;
    logic            wstb_q_n;
    logic [1:0]      adr_lat;
    logic [1:0]      adr_eff;
    logic [CH_N-1:0] sel_q;
    logic            wstb_fall;

    assign wstb_fall = wstb_q_n & ~wstb_s_n;
    assign adr_eff   = wstb_fall ? adr_s : adr_lat;

    always_comb begin
        unique case ({wstb_s_n, load_s})
            2'b10: st_nxt = MODE_IDLE;
            2'b00: st_nxt = MODE_CAPTURE;
            2'b11: st_nxt = MODE_UPDATE;
            2'b01: st_nxt = MODE_PASS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= MODE_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // companions of the state: strobe history, address latch, selection, data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wstb_q_n <= 1'b1;
            adr_lat  <= ADR_BOTH;
            sel_q    <= '0;
            dat_q    <= '0;
        end else begin
            wstb_q_n <= wstb_s_n;
            if (wstb_fall) begin
                adr_lat <= adr_s;
            end
            sel_q <= adr_decode(adr_eff);
            dat_q <= dat_s;
        end
    end

    // outputs
    always_comb begin
        stage_we       = '0;
        out_from_stage = '0;
        out_from_bus   = '0;
        unique case (st)
            MODE_IDLE: begin
            end
            MODE_CAPTURE: begin
                stage_we = sel_q;
            end
            MODE_UPDATE: begin
                out_from_stage = sel_q;
            end
            MODE_PASS: begin
                stage_we     = sel_q;
                out_from_bus = sel_q;
            end
        endcase
    end

    // R5: the no-channel code never produces a selection
    p_none_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb_fall && adr_s == ADR_NONE) |=> (sel_q == '0));

    // R10: the latch only moves on a falling synchronised strobe
    p_lat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wstb_q_n == 1'b0) |=> $stable(adr_lat));
endmodule

// File: rtl/dacif_chan.sv
module dacif_chan #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] rst_code,
    input  logic          stage_we,
    input  logic          from_stage,
    input  logic          from_bus,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] code
);
    logic [DW-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= rst_code;
        end else if (stage_we) begin
            stage_q <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= rst_code;
        end else if (from_bus) begin
            code <= din;
        end else if (from_stage) begin
            code <= stage_q;
        end
    end

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_we |=> (stage_q == $past(din)));

    p_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (from_stage && !from_bus) |=> (code == $past(stage_q)));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        from_bus |=> (code == $past(din)));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(from_stage || from_bus) |=> $stable(code));
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dacif_pkg::*;
#(
    parameter int DW          = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr_n,
    input  logic          clr_mid,
    input  logic          wstb_n,
    input  logic          load_en,
    input  logic [1:0]    sel_addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] code_a,
    output logic [DW-1:0] code_b
);
    localparam logic [DW-1:0] MID_CODE = DW'(1) << (DW - 1);

    logic            rst_int_n;
    logic [DW-1:0]   rst_code;
    logic [1:0]      ctl_s;
    logic [1:0]      adr_s;
    logic [DW-1:0]   dat_s;
    logic [DW-1:0]   dat_q;
    logic [CH_N-1:0] stage_we, from_stage, from_bus;
    logic [DW-1:0]   codes [CH_N];

    assign rst_code = clr_mid ? MID_CODE : '0;

    dacif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(clk), .arst_n(por_n & clr_n), .rst_sync_n(rst_int_n)
    );

    dacif_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync_ctl (
        .clk(clk), .rst_n(rst_int_n), .d_in({wstb_n, load_en}), .d_out(ctl_s)
    );

    dacif_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync_adr (
        .clk(clk), .rst_n(rst_int_n), .d_in(sel_addr), .d_out(adr_s)
    );

    dacif_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
        .clk(clk), .rst_n(rst_int_n), .d_in(din), .d_out(dat_s)
    );

    dacif_ctrl_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_int_n),
        .wstb_s_n(ctl_s[1]), .load_s(ctl_s[0]),
        .adr_s(adr_s), .dat_s(dat_s),
        .stage_we(stage_we), .out_from_stage(from_stage),
        .out_from_bus(from_bus), .dat_q(dat_q)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        dacif_chan #(.DW(DW)) u_chan (
            .clk(clk), .rst_n(rst_int_n), .rst_code(rst_code),
            .stage_we(stage_we[c]), .from_stage(from_stage[c]),
            .from_bus(from_bus[c]), .din(dat_q), .code(codes[c])
        );
    end

    assign code_a = codes[0];
    assign code_b = codes[1];

    // R2, R3: a held reset leaves the selected reset code on both outputs
    p_reset_code_r2: assert property (@(posedge clk) disable iff (!por_n)
        !rst_int_n |=> (code_a == $past(rst_code) && code_b == $past(rst_code)));
endmodule

// File: tb/dual_dac_regif_tb.sv
module dual_dac_regif_tb_top;
    localparam int CLK_P   = 10;
    localparam int DW      = 14;
    localparam int SYNC_ST = 2;
    localparam int LAT     = SYNC_ST + 1;
    localparam int MIDV    = 'h2000;

    logic          clk      = 1'b0;
    logic          por_n    = 1'b0;
    logic          clr_n    = 1'b1;
    logic          clr_mid  = 1'b0;
    logic          wstb_n   = 1'b1;
    logic          load_en  = 1'b0;
    logic [1:0]    sel_addr = 2'b01;
    logic [DW-1:0] din      = '0;
    logic [DW-1:0] code_a, code_b;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    dual_dac_regif #(.DW(DW), .SYNC_STAGES(SYNC_ST)) dut_i (
        .clk(clk), .por_n(por_n), .clr_n(clr_n), .clr_mid(clr_mid),
        .wstb_n(wstb_n), .load_en(load_en), .sel_addr(sel_addr), .din(din),
        .code_a(code_a), .code_b(code_b)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int h_wr[$], h_ld[$], h_ad[$], h_dt[$];
    int m_stage[2], m_out[2];
    int m_lat  = 2;
    int rcnt   = 0;
    int rcode;

    function automatic int code_of(input logic mid);
        return mid ? MIDV : 0;
    endfunction

    initial begin
        for (int i = 0; i < LAT + 2; i++) begin
            h_wr.push_front(1); h_ld.push_front(0); h_ad.push_front(1); h_dt.push_front(0);
        end
    end

    always @(posedge clk) begin
        rcode = code_of(clr_mid);
        if (!(por_n && clr_n)) rcnt = 0;
        else if (rcnt < 100) rcnt++;
        if (!(por_n && clr_n) || rcnt <= SYNC_ST) begin
            h_wr.push_front(1); h_ld.push_front(0); h_ad.push_front(1); h_dt.push_front(0);
            for (int c = 0; c < 2; c++) begin m_stage[c] = rcode; m_out[c] = rcode; end
            m_lat = 2;
        end else begin
            h_wr.push_front(int'(wstb_n)); h_ld.push_front(int'(load_en));
            h_ad.push_front(int'(sel_addr)); h_dt.push_front(int'(din));
            if (h_wr[LAT] == 0 && h_wr[LAT+1] == 1) m_lat = h_ad[LAT];
            for (int c = 0; c < 2; c++) begin
                bit hit;
                hit = (m_lat == 2) || (c == 0 && m_lat == 0) || (c == 1 && m_lat == 3);
                if (hit) begin
                    if (h_wr[LAT] == 0) begin
                        m_stage[c] = h_dt[LAT];
                        if (h_ld[LAT] == 1) m_out[c] = h_dt[LAT];
                    end else if (h_ld[LAT] == 1) begin
                        m_out[c] = m_stage[c];
                    end
                end
            end
        end
        void'(h_wr.pop_back()); void'(h_ld.pop_back());
        void'(h_ad.pop_back()); void'(h_dt.pop_back());
    end

    // per-cycle comparison, sampled away from both clock edges (R11 timing)
    always @(posedge clk) begin
        #3;
        if (!(por_n && clr_n)) begin
            chk("R11 model A", code_a, DW'(code_of(clr_mid)));
            chk("R11 model B", code_b, DW'(code_of(clr_mid)));
        end else begin
            chk("R11 model A", code_a, DW'(m_out[0]));
            chk("R11 model B", code_b, DW'(m_out[1]));
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        sel_addr = a; din = d;
        tick(1); wstb_n = 1'b0;
        tick(2); wstb_n = 1'b1;
        tick(1);
    endtask

    task automatic bus_load();
        load_en = 1'b1;
        tick(2); load_en = 1'b0;
        tick(1);
    endtask

    initial begin
        tick(3);
        chk("R1 por zero A", code_a, 14'h0000);
        chk("R2 zero code B", code_b, 14'h0000);
        por_n = 1'b1;
        tick(4);

        bus_write(2'b00, 14'h1234); tick(6);
        chk("R4 capture hidden A", code_a, 14'h0000);
        bus_load(); tick(6);
        chk("R6 update A", code_a, 14'h1234);
        chk("R5 A only B", code_b, 14'h0000);

        bus_write(2'b11, 14'h0ABC); bus_load(); tick(6);
        chk("R5 B sel", code_b, 14'h0ABC);
        chk("R6 A kept", code_a, 14'h1234);

        bus_write(2'b01, 14'h3FFF); bus_load(); tick(6);
        chk("R5 none A", code_a, 14'h1234);
        chk("R5 none B", code_b, 14'h0ABC);

        bus_write(2'b10, 14'h2222); bus_load(); tick(6);
        chk("R5 both A", code_a, 14'h2222);
        chk("R5 both B", code_b, 14'h2222);

        sel_addr = 2'b00; din = 14'h1111; clr_mid = 1'b1;
        tick(8);
        chk("R7 hold A", code_a, 14'h2222);
        chk("R7 hold B", code_b, 14'h2222);

        din = 14'h0555;
        tick(1);
        wstb_n = 1'b0; load_en = 1'b1;
        tick(3);
        chk("R11 edge3 A", code_a, 14'h2222);
        tick(1);
        chk("R11 edge4 A", code_a, 14'h0555);
        chk("R8 pass other B", code_b, 14'h2222);
        wstb_n = 1'b1; load_en = 1'b0;
        tick(6);
        chk("R8 pass A", code_a, 14'h0555);

        load_en = 1'b1; tick(2);
        sel_addr = 2'b11; din = 14'h3001; tick(1);
        wstb_n = 1'b0; load_en = 1'b0; tick(3);
        wstb_n = 1'b1; load_en = 1'b1; tick(6);
        chk("R9 tied B", code_b, 14'h3001);
        chk("R9 tied A", code_a, 14'h0555);
        load_en = 1'b0; tick(2);

        sel_addr = 2'b00; din = 14'h0111; tick(1);
        wstb_n = 1'b0; tick(2);
        sel_addr = 2'b11; tick(2);
        wstb_n = 1'b1; tick(1);
        bus_load(); tick(6);
        chk("R10 latched A", code_a, 14'h0111);
        chk("R10 latched B", code_b, 14'h3001);

        bus_write(2'b00, 14'h0777); tick(6);
        wstb_n = 1'b0; load_en = 1'b1; sel_addr = 2'b10; din = 14'h1555; clr_n = 1'b0;
        #1;
        chk("R3 async A", code_a, 14'h2000);
        chk("R3 async B", code_b, 14'h2000);
        tick(3);
        chk("R3 priority A", code_a, 14'h2000);
        chk("R2 mid B", code_b, 14'h2000);
        wstb_n = 1'b1; load_en = 1'b0; clr_n = 1'b1;
        tick(6);
        bus_load(); tick(6);
        chk("R3 stage reset A", code_a, 14'h2000);
        chk("R3 stage reset B", code_b, 14'h2000);

        por_n = 1'b0; tick(2);
        chk("R1 por mid A", code_a, 14'h2000);
        clr_mid = 1'b0; tick(2);
        chk("R2 follow select A", code_a, 14'h0000);
        chk("R2 follow select B", code_b, 14'h0000);
        por_n = 1'b1; tick(6);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule